// File: doc/BRIEF.md
# Timer Tick Prescaler with Source Select

This block produces the count enable for an 8-bit timer. A source-select input picks the clock the timer logic runs on: the system clock or a second, asynchronous oscillator clock. The switch between the two is glitch-free, and the block drives the chosen clock out as `tmr_clk`. A 10-bit prescaler counts every edge of that clock and runs freely. A 3-bit select code turns its low bits into a one-cycle `tick` enable. The code can stop the timer, pass every cycle through, or pick one of six fixed division ratios.

Software gets a known tick phase by pulsing the prescaler clear. The clearing edge forces the count to zero. The first divided tick then follows a fixed number of timer-clock cycles later. Changing the select code alone never disturbs the count, so a new ratio starts at the phase the counter already has. `clk_sel` and `presc_clr` are synchronous to `tmr_clk`. `tick` is meant to be used as an enable in that same domain.

Top module: `tmr_tick_gen`

## Requirements
- R1: The prescaler advances by one on every `tmr_clk` rising edge and wraps modulo 1024, whatever the select code. Code 000 does not hold the count.
- R2: With `src_sel` = 0, `tmr_clk` follows `sys_clk`. With `src_sel` = 1, it follows `ext_clk`. During a switch, both sources are never gated through at the same time.
- R3: Select code 000 stops the timer, and `tick` stays low.
- R4: Select code 001 holds `tick` high in every timer cycle (no division).
- R5: Select codes 010, 011, 100, 101, 110 and 111 give a divide-by ratio N of 8, 32, 64, 128, 256 and 1024. `tick` is high for one cycle in every N, namely in the cycles where the low log2(N) bits of the prescaler are all ones.
- R6: When `presc_clr` is sampled high at an edge, the count becomes zero. The first divided tick is observed N-1 cycles after that edge. While `presc_clr` stays high the count stays zero, and no divided tick occurs.
- R7: A new `clk_sel` value is registered on the next `tmr_clk` edge and does not reset the prescaler.
- R8: During reset, the count and the registered code are zero, `tick` is low and `tmr_clk` is gated off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, one of the two sources |
| ext_clk | input | 1 | Asynchronous oscillator clock, the other source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source choice: 0 system clock, 1 oscillator clock |
| clk_sel | input | 3 | Stop, pass-through or divide code (R3 to R5) |
| presc_clr | input | 1 | Prescaler clear strobe, synchronous to tmr_clk |
| tmr_clk | output | 1 | Selected, glitch-free timer clock |
| tick | output | 1 | One-cycle timer count enable in the tmr_clk domain |

## Verification
Each select code is applied after a clear on both sources. The bench measures the latency to the first tick and the spacing between ticks; these separate a wrong tap or code order from a wrong clear phase. Directed runs do four things: switch the code in mid-count, switch from the stop code, hold the clear for many cycles, and measure the timer clock period. These show that the counter keeps running under a code change and that the source mux picks the right clock. Random runs pair random codes with random run lengths and compare every cycle's tick against a bench model of the count since the clear.

// File: rtl/tmr_tick_pkg.sv
`timescale 1ns/1ps
package tmr_tick_pkg;

   typedef enum logic [2:0] {
      CS_STOP    = 3'd0,
      CS_DIV1    = 3'd1,
      CS_DIV8    = 3'd2,
      CS_DIV32   = 3'd3,
      CS_DIV64   = 3'd4,
      CS_DIV128  = 3'd5,
      CS_DIV256  = 3'd6,
      CS_DIV1024 = 3'd7
   } clk_sel_e;

   localparam int NUM_TAPS     = 6;
   localparam int TAP_MAX_LOG2 = 10;

   // log2 of the ratio for divided tap index (code minus 2)
   function automatic int tap_log2(input int idx);
      case (idx)
         0:       return 3;
         1:       return 5;
         2:       return 6;
         3:       return 7;
         4:       return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux #(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_EXT     = 1'b1
) (
   input  logic sys_clk,
   input  logic ext_clk,
   input  logic rst_n,
   input  logic src_sel,
   output logic tmr_clk
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         initial $fatal(1, "clk_src_mux: SYNC_STAGES must be at least 2");
      end

      if (HAS_EXT) begin : g_mux
         localparam int MSB = SYNC_STAGES - 1;
         logic [MSB:0] s_chain;
         logic [MSB:0] e_chain;
         logic         en_s;
         logic         en_e;

         assign en_s = s_chain[MSB];
         assign en_e = e_chain[MSB];

         // enables move only while their own clock is low
         always_ff @(negedge sys_clk or negedge rst_n) begin
            if (!rst_n) s_chain <= '0;
            else        s_chain <= {s_chain[MSB-1:0], ~src_sel & ~en_e};
         end

         always_ff @(negedge ext_clk or negedge rst_n) begin
            if (!rst_n) e_chain <= '0;
            else        e_chain <= {e_chain[MSB-1:0], src_sel & ~en_s};
         end

         assign tmr_clk = (sys_clk & en_s) | (ext_clk & en_e);

         a_r2_one_source: assert property (@(posedge sys_clk) disable iff (!rst_n)
            !(en_s && en_e))
            else $error("R2: both clock sources enabled");
      end else begin : g_sys_only
         logic unused_in;
         assign unused_in = ext_clk ^ src_sel ^ rst_n;
         assign tmr_clk   = sys_clk;
      end
   endgenerate

endmodule

// File: rtl/presc_counter.sv
`timescale 1ns/1ps
module presc_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(clr)) |-> (cnt == $past(cnt) + 1'b1))
      else $error("R1: prescaler did not advance by one");

   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0))
      else $error("R6: clear did not zero the prescaler");

endmodule

// File: rtl/tap_select.sv
`timescale 1ns/1ps
module tap_select
   import tmr_tick_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  clk_sel_e         sel_in,
   input  logic [CNT_W-1:0] cnt,
   output clk_sel_e         sel_q,
   output logic             tick
);

   logic [NUM_TAPS-1:0] hit;
   logic [2:0]          tap_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= CS_STOP;
      else        sel_q <= sel_in;
   end

   generate
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
         localparam int L = tap_log2(t);
         assign hit[t] = &cnt[L-1:0];
      end
   endgenerate

   assign tap_idx = 3'(sel_q) - 3'd2;

   always_comb begin
      case (sel_q)
         CS_STOP: tick = 1'b0;
         CS_DIV1: tick = 1'b1;
         default: tick = hit[tap_idx];
      endcase
   end

endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen
   import tmr_tick_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_EXT     = 1'b1
) (
   input  logic       sys_clk,
   input  logic       ext_clk,
   input  logic       rst_n,
   input  logic       src_sel,
   input  logic [2:0] clk_sel,
   input  logic       presc_clr,
   output logic       tmr_clk,
   output logic       tick
);

   generate
      if (CNT_W < TAP_MAX_LOG2) begin : g_bad_width
         initial $fatal(1, "tmr_tick_gen: CNT_W too small for the widest tap");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   clk_sel_e         sel_q;

   clk_src_mux #(.SYNC_STAGES(SYNC_STAGES), .HAS_EXT(HAS_EXT)) u_mux (
      .sys_clk (sys_clk),
      .ext_clk (ext_clk),
      .rst_n   (rst_n),
      .src_sel (src_sel),
      .tmr_clk (tmr_clk)
   );

   presc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (tmr_clk),
      .rst_n (rst_n),
      .clr   (presc_clr),
      .cnt   (cnt)
   );

   tap_select #(.CNT_W(CNT_W)) u_tap (
      .clk    (tmr_clk),
      .rst_n  (rst_n),
      .sel_in (clk_sel_e'(clk_sel)),
      .cnt    (cnt),
      .sel_q  (sel_q),
      .tick   (tick)
   );

   logic armed;
   always_ff @(posedge tmr_clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r3_stop_quiet: assert property (@(posedge tmr_clk) disable iff (!rst_n)
      (sel_q == CS_STOP) |-> !tick)
      else $error("R3: tick while stopped");

   a_r4_pass_every: assert property (@(posedge tmr_clk) disable iff (!rst_n)
      (sel_q == CS_DIV1) |-> tick)
      else $error("R4: pass-through missed a cycle");

   a_r7_keep_phase: assert property (@(posedge tmr_clk) disable iff (!rst_n)
      (armed && (sel_q != $past(sel_q)) && !$past(presc_clr)) |-> (cnt == $past(cnt) + 1'b1))
      else $error("R7: code change disturbed the prescaler");

   a_r8_reset_idle: assert property (@(posedge tmr_clk) disable iff (!rst_n)
      !armed |-> (cnt == '0 || cnt == 1))
      else $error("R8: prescaler not cleared by reset");

endmodule

// File: tb/tmr_tick_gen_bench.sv
`timescale 1ns/1ps
module tmr_tick_gen_bench;

   logic       sys_clk = 1'b0;
   logic       ext_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       src_sel = 1'b0;
   logic [2:0] clk_sel = 3'd0;
   logic       presc_clr = 1'b0;
   logic       tmr_clk;
   logic       tick;

   int vectors     = 0;
   int miscompares = 0;
   bit done        = 1'b0;

   always #4 sys_clk = ~sys_clk;
   initial begin
      #3;
      forever #15 ext_clk = ~ext_clk;
   end

   tmr_tick_gen u_tmr_tick_gen (
      .sys_clk   (sys_clk),
      .ext_clk   (ext_clk),
      .rst_n     (rst_n),
      .src_sel   (src_sel),
      .clk_sel   (clk_sel),
      .presc_clr (presc_clr),
      .tmr_clk   (tmr_clk),
      .tick      (tick)
   );

   function automatic int ratio(input int code);
      case (code)
         0: return 0;
         1: return 1;
         2: return 8;
         3: return 32;
         4: return 64;
         5: return 128;
         6: return 256;
         default: return 1024;
      endcase
   endfunction

   // expected tick k cycles after a clearing edge
   function automatic int exp_tick(input int code, input int k);
      if (code == 0) return 0;
      if (code == 1) return 1;
      return ((k % ratio(code)) == ratio(code) - 1) ? 1 : 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // clear, then k = 0 at the negedge after the clearing edge
   task automatic clear_with(input int code);
      @(negedge tmr_clk);
      clk_sel   = 3'(code);
      presc_clr = 1'b1;
      @(negedge tmr_clk);
      presc_clr = 1'b0;
   endtask

   task automatic measure(input int code, input string req);
      int first  = -1;
      int second = -1;
      clear_with(code);
      for (int k = 0; k < 2100 && second < 0; k++) begin
         if (k > 0) @(negedge tmr_clk);
         if (tick) begin
            if (first < 0) first = k;
            else           second = k;
         end
      end
      if (code == 0) begin
         chk({req, " stopped, first tick"}, first, -1);
      end else begin
         chk({req, " first tick latency"}, first, ratio(code) - 1);
         chk({req, " tick period"}, second - first, ratio(code));
      end
   endtask

   task automatic clk_period(input int exp_ns, input string req);
      realtime t0, t1;
      repeat (20) @(posedge tmr_clk);
      t0 = $realtime;
      @(posedge tmr_clk);
      t1 = $realtime;
      chk(req, int'(t1 - t0), exp_ns);
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int first;
      int cnt_t;
      void'($urandom(32'd20250611));

      // R8: reset state
      #50;
      chk("R8 tick in reset", int'(tick), 0);
      chk("R8 tmr_clk gated in reset", int'(tmr_clk), 0);
      #3 rst_n = 1'b1;
      @(negedge tmr_clk);
      chk("R8 tick after reset with stop code", int'(tick), 0);

      // R2: system clock period
      clk_period(8, "R2 system source period");

      // R3, R4, R5, R6: every code, directed
      for (int c = 0; c < 8; c++) measure(c, $sformatf("R5 code %0d", c));

      // R1: counter keeps running under stop code
      clear_with(0);
      for (int k = 1; k <= 500; k++) @(negedge tmr_clk);
      clk_sel = 3'd6;
      first = -1;
      for (int k = 500; k < 800 && first < 0; k++) begin
         if (k > 500) @(negedge tmr_clk);
         if (k > 500 && tick) first = k;
      end
      chk("R1 counter ran while stopped", first, 511);

      // R7: code change mid-count keeps phase
      clear_with(2);
      for (int k = 1; k <= 12; k++) @(negedge tmr_clk);
      clk_sel = 3'd3;
      first = -1;
      for (int k = 13; k < 200 && first < 0; k++) begin
         @(negedge tmr_clk);
         if (tick) first = k;
      end
      chk("R7 first tick after code change", first, 31);

      // R6: clear held for many cycles
      @(negedge tmr_clk);
      clk_sel   = 3'd2;
      presc_clr = 1'b1;
      cnt_t = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge tmr_clk);
         cnt_t += int'(tick);
      end
      chk("R6 ticks while clear held", cnt_t, 0);
      presc_clr = 1'b0;
      first = -1;
      for (int k = 1; k < 50 && first < 0; k++) begin
         @(negedge tmr_clk);
         if (tick) first = k;
      end
      chk("R6 latency after held clear", first, 7);

      // R2: oscillator source
      @(negedge tmr_clk);
      src_sel = 1'b1;
      clk_period(30, "R2 oscillator source period");
      measure(2, "R2 R5 oscillator /8");
      measure(7, "R2 R5 oscillator /1024");
      measure(1, "R2 R4 oscillator pass");
      @(negedge tmr_clk);
      src_sel = 1'b0;
      clk_period(8, "R2 back to system source");

      // R5: random codes and run lengths
      for (int r = 0; r < 30; r++) begin
         int code = int'($urandom_range(0, 7));
         int len  = int'($urandom_range(1, 300));
         int bad  = 0;
         clear_with(code);
         for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge tmr_clk);
            if (int'(tick) != exp_tick(code, k)) bad++;
         end
         chk($sformatf("R5 random code %0d len %0d mismatches", code, len), bad, 0);
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule